// File: doc/BRIEF.md
# Instruction Fetch Translation and Steering Path

This block stands between a processor's instruction-fetch port and the on-chip instruction stores. Each fetch carries a virtual address. A four-entry, fully associative micro-TLB translates that address. The block then compares the physical address against a programmable scratchpad window and sends the fetch to one of three places: the scratchpad, a small mini-cache, or an uncached external port. The block handles instruction fetches only, so no data access ever passes through the scratchpad path.

On a micro-TLB miss, the block stalls the fetch and asks a unified TLB/MMU for the page over a simple request/response port. The reply carries the physical page, a present bit and a two-bit page class. A page that is absent, or that has the reserved class, is never installed. The fetch then completes with a fault, so that management software can place the page in the scratchpad and mark it present. A flush input empties the micro-TLB in one cycle. Responses come out in request order through a valid/ready handshake.

Top module: `ifetch_xlate`

## Requirements
- R1: A fetch whose page hits in the micro-TLB is answered in the cycle after it is accepted. The physical address is the stored physical page joined with the 12-bit page offset, and the fault flag is low.
- R2: A translated address with spm_base_i <= address < spm_limit_i goes to target code 0 (scratchpad), whatever its page class.
- R3: A translated address outside the window, with class 00 (cacheable) or 10 (pageable), goes to target code 1 (mini-cache).
- R4: On a miss, mmu_req_valid_o rises in the cycle after acceptance and carries the virtual page number. It holds with that page number until mmu_rsp_valid_i is seen. req_ready_o stays low for that whole time, and the response appears in the cycle after the refill reply.
- R5: A translated address outside the window, with class 01 (non-cacheable), goes to target code 2 (uncached).
- R6: A refill reply whose present bit is 0, or whose class is 11, produces a response with the fault flag high, target code 3 and a physical address of zero. The page is not installed, so a later fetch to it misses again.
- R7: Valid refills fill the four entries in round-robin order. The fifth distinct page replaces the page that was filled first.
- R8: A one-cycle flush pulse invalidates every entry. A fetch accepted in the same cycle as a flush is treated as a miss.
- R9: While rsp_ready_i is low, a pending response keeps its address, target and fault values, and no new fetch is accepted.
- R10: After reset, req_ready_o is high, rsp_valid_o and mmu_req_valid_o are low, and the micro-TLB is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all micro-TLB entries |
| spm_base_i | input | PA_W | First physical address of the scratchpad window |
| spm_limit_i | input | PA_W | First physical address past the scratchpad window |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Fetch request can be accepted |
| req_vaddr_i | input | VA_W | Virtual fetch address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_paddr_o | output | PA_W | Translated physical address |
| rsp_target_o | output | 2 | 0 scratchpad, 1 mini-cache, 2 uncached, 3 none |
| rsp_fault_o | output | 1 | Page-table exception for this fetch |
| mmu_req_valid_o | output | 1 | Refill request to the unified TLB/MMU |
| mmu_req_vpn_o | output | VA_W-12 | Virtual page to refill |
| mmu_rsp_valid_i | input | 1 | Refill reply valid |
| mmu_rsp_ppn_i | input | PA_W-12 | Physical page of the reply |
| mmu_rsp_class_i | input | 2 | Page class of the reply |
| mmu_rsp_present_i | input | 1 | Page entry valid bit of the reply |

## Verification
The stimulus first exercises single pages at each edge of the window: the first and last pages inside it, the page that starts exactly at the limit, and the page just below the base. These separate an off-by-one in the comparator from a class-decoding error. A run of five distinct pages after four fills exposes the replacement order: the page that survives hits in one cycle, and the evicted page raises a new refill. Repeated fetches to an absent page, and to a reserved-class page, show whether a faulting reply is wrongly installed. A flush pulse on its own and a flush together with a fetch both test invalidation, and a held-off consumer tests that the response stays stable and that fetches are refused meanwhile.

// File: rtl/ifx_pkg.sv
// Shared encodings for the instruction-fetch translation path.
// Assumes 2-bit page classes and 2-bit fetch targets at every interface.
package ifx_pkg;
    typedef enum logic [1:0] {
        PC_CACHED   = 2'b00,
        PC_UNCACHED = 2'b01,
        PC_PAGEABLE = 2'b10,
        PC_RSVD     = 2'b11
    } pg_class_e;

    typedef enum logic [1:0] {
        TG_SPM  = 2'd0,
        TG_MINI = 2'd1,
        TG_UNC  = 2'd2,
        TG_NONE = 2'd3
    } fetch_tgt_e;
endpackage

// File: rtl/ifx_utlb.sv
// Fully associative micro-TLB with a combinational lookup and round-robin fill.
// Assumes that only valid, non-reserved pages are written, so a hit needs no
// further check. A flush clears every entry; a write in the same cycle still lands.
module ifx_utlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o,
    output logic [1:0]       lk_cls_o,
    input  logic             wr_en_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [PPN_W-1:0] wr_ppn_i,
    input  logic [1:0]       wr_cls_i
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [1:0]         cls_q [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;

    // One tag comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);
    end

    // Select the matching entry; a flush in the same cycle forces a miss.
    always_comb begin
        lk_ppn_o = '0;
        lk_cls_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_ppn_o = lk_ppn_o | ({PPN_W{match[i]}} & ppn_q[i]);
            lk_cls_o = lk_cls_o | ({2{match[i]}} & cls_q[i]);
        end
        lk_hit_o = (|match) && !flush_i;
    end

    // Entry storage: flush clears, refill writes at the round-robin slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
                cls_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en_i && (IDX_W'(i) == ptr_q)) begin
                    vld_q[i] <= 1'b1;
                    vpn_q[i] <= wr_vpn_i;
                    ppn_q[i] <= wr_ppn_i;
                    cls_q[i] <= wr_cls_i;
                end else if (flush_i) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // Replacement pointer advances once per installed page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en_i) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ifx_route.sv
// Chooses the fetch target from a physical address and its page class.
// Assumes the window is half-open: base inclusive, limit exclusive.
// The window match takes priority over the class.
module ifx_route
    import ifx_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic [PA_W-1:0] pa_i,
    input  logic [PA_W-1:0] base_i,
    input  logic [PA_W-1:0] limit_i,
    input  logic [1:0]      cls_i,
    output logic [1:0]      tgt_o
);
    logic in_win;

    // Window comparator followed by the class decode.
    always_comb begin
        in_win = (pa_i >= base_i) && (pa_i < limit_i);
        if (in_win)                                tgt_o = TG_SPM;
        else if (pg_class_e'(cls_i) == PC_UNCACHED) tgt_o = TG_UNC;
        else                                       tgt_o = TG_MINI;
    end
endmodule

// File: rtl/ifetch_xlate.sv
// Instruction-fetch translation path: micro-TLB lookup, refill on a miss,
// window steering and an in-order response register.
// Assumes one outstanding refill and a single-entry response stage.
module ifetch_xlate
    import ifx_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PG_OFF_W = 12,
    parameter int TLB_N    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic [PA_W-1:0]        spm_base_i,
    input  logic [PA_W-1:0]        spm_limit_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [VA_W-1:0]        req_vaddr_i,
    output logic                   rsp_valid_o,
    input  logic                   rsp_ready_i,
    output logic [PA_W-1:0]        rsp_paddr_o,
    output logic [1:0]             rsp_target_o,
    output logic                   rsp_fault_o,
    output logic                   mmu_req_valid_o,
    output logic [VA_W-PG_OFF_W-1:0] mmu_req_vpn_o,
    input  logic                   mmu_rsp_valid_i,
    input  logic [PA_W-PG_OFF_W-1:0] mmu_rsp_ppn_i,
    input  logic [1:0]             mmu_rsp_class_i,
    input  logic                   mmu_rsp_present_i
);
    localparam int VPN_W = VA_W - PG_OFF_W;
    localparam int PPN_W = PA_W - PG_OFF_W;

    logic                busy_q;
    logic [VPN_W-1:0]    miss_vpn_q;
    logic [PG_OFF_W-1:0] miss_off_q;
    logic                accept, lk_hit, refill_done, refill_ok;
    logic [PPN_W-1:0]    lk_ppn;
    logic [1:0]          lk_cls, rt_cls, rt_tgt;
    logic [PA_W-1:0]     rt_pa;

    assign req_ready_o     = !busy_q && (!rsp_valid_o || rsp_ready_i);
    assign accept          = req_valid_i && req_ready_o;
    assign refill_done     = busy_q && mmu_rsp_valid_i;
    assign refill_ok       = mmu_rsp_present_i && (pg_class_e'(mmu_rsp_class_i) != PC_RSVD);
    assign mmu_req_valid_o = busy_q;
    assign mmu_req_vpn_o   = miss_vpn_q;

    ifx_utlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_utlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .lk_vpn_i (req_vaddr_i[VA_W-1:PG_OFF_W]),
        .lk_hit_o (lk_hit),
        .lk_ppn_o (lk_ppn),
        .lk_cls_o (lk_cls),
        .wr_en_i  (refill_done && refill_ok),
        .wr_vpn_i (miss_vpn_q),
        .wr_ppn_i (mmu_rsp_ppn_i),
        .wr_cls_i (mmu_rsp_class_i)
    );

    // Route input comes from the refill reply while one returns, else from the lookup.
    always_comb begin
        if (refill_done) begin
            rt_pa  = {mmu_rsp_ppn_i, miss_off_q};
            rt_cls = mmu_rsp_class_i;
        end else begin
            rt_pa  = {lk_ppn, req_vaddr_i[PG_OFF_W-1:0]};
            rt_cls = lk_cls;
        end
    end

    ifx_route #(.PA_W(PA_W)) u_route (
        .pa_i    (rt_pa),
        .base_i  (spm_base_i),
        .limit_i (spm_limit_i),
        .cls_i   (rt_cls),
        .tgt_o   (rt_tgt)
    );

    // Miss tracking: enter refill on a missed fetch, leave on the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            miss_vpn_q <= '0;
            miss_off_q <= '0;
        end else if (refill_done) begin
            busy_q <= 1'b0;
        end else if (accept && !lk_hit) begin
            busy_q     <= 1'b1;
            miss_vpn_q <= req_vaddr_i[VA_W-1:PG_OFF_W];
            miss_off_q <= req_vaddr_i[PG_OFF_W-1:0];
        end
    end

    // Response stage: loaded by a hit or a refill reply, emptied when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_paddr_o  <= '0;
            rsp_target_o <= TG_NONE;
            rsp_fault_o  <= 1'b0;
        end else if (refill_done) begin
            rsp_valid_o  <= 1'b1;
            rsp_fault_o  <= !refill_ok;
            rsp_paddr_o  <= refill_ok ? rt_pa : '0;
            rsp_target_o <= refill_ok ? rt_tgt : TG_NONE;
        end else if (accept && lk_hit) begin
            rsp_valid_o  <= 1'b1;
            rsp_fault_o  <= 1'b0;
            rsp_paddr_o  <= rt_pa;
            rsp_target_o <= rt_tgt;
        end else if (rsp_ready_i) begin
            rsp_valid_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/ifetch_xlate_chk.sv
// Protocol checker for the fetch translation path, bound to the top module.
// Assumes it observes the top ports and the micro-TLB hit signal.
module ifetch_xlate_chk #(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PG_OFF_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush_i,
    input logic                     req_valid_i,
    input logic                     req_ready_o,
    input logic [VA_W-1:0]          req_vaddr_i,
    input logic                     rsp_valid_o,
    input logic                     rsp_ready_i,
    input logic [PA_W-1:0]          rsp_paddr_o,
    input logic [1:0]               rsp_target_o,
    input logic                     rsp_fault_o,
    input logic                     mmu_req_valid_o,
    input logic [VA_W-PG_OFF_W-1:0] mmu_req_vpn_o,
    input logic                     mmu_rsp_valid_i,
    input logic                     lk_hit
);
    logic acc;
    assign acc = req_valid_i && req_ready_o;

    AST_HIT_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && lk_hit |=> rsp_valid_o && !rsp_fault_o); // R1
    AST_MISS_REFILL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !lk_hit |=> mmu_req_valid_o && (mmu_req_vpn_o == $past(req_vaddr_i[VA_W-1:PG_OFF_W]))); // R4
    AST_REFILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_req_valid_o |-> !req_ready_o); // R4
    AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_req_valid_o && !mmu_rsp_valid_i |=> mmu_req_valid_o && $stable(mmu_req_vpn_o)); // R4
    AST_REFILL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_req_valid_o && mmu_rsp_valid_i |=> rsp_valid_o && !mmu_req_valid_o); // R4
    AST_FAULT_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> (rsp_target_o == 2'd3) && (rsp_paddr_o == '0)); // R6
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && flush_i |=> mmu_req_valid_o); // R8
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
            && $stable(rsp_target_o) && $stable(rsp_fault_o)); // R9
endmodule

bind ifetch_xlate ifetch_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_OFF_W(PG_OFF_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush_i         (flush_i),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_vaddr_i     (req_vaddr_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_target_o    (rsp_target_o),
    .rsp_fault_o     (rsp_fault_o),
    .mmu_req_valid_o (mmu_req_valid_o),
    .mmu_req_vpn_o   (mmu_req_vpn_o),
    .mmu_rsp_valid_i (mmu_rsp_valid_i),
    .lk_hit          (lk_hit)
);

// File: tb/ifetch_xlate_tb_top.sv
// Bench: a behavioural reference model updated on each rising edge and
// compared with the design on each falling edge, plus directed fetch checks.
module ifetch_xlate_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] base = 32'h0008_0000;
    logic [31:0] limit = 32'h0008_4000;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic        rsp_ready = 1'b1;
    logic        mmu_rsp_valid = 1'b0;
    logic [19:0] mmu_ppn = '0;
    logic [1:0]  mmu_cls = '0;
    logic        mmu_pres = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault, mmu_req_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_target;
    logic [19:0] mmu_vpn;

    int n_cmp = 0;
    int n_bad = 0;

    always #(PERIOD / 2) clk = ~clk;

    ifetch_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .spm_base_i(base), .spm_limit_i(limit),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(vaddr),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
        .rsp_target_o(rsp_target), .rsp_fault_o(rsp_fault),
        .mmu_req_valid_o(mmu_req_valid), .mmu_req_vpn_o(mmu_vpn),
        .mmu_rsp_valid_i(mmu_rsp_valid), .mmu_rsp_ppn_i(mmu_ppn),
        .mmu_rsp_class_i(mmu_cls), .mmu_rsp_present_i(mmu_pres)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Page table seen by the refill responder: {present, class, ppn}.
    function automatic logic [22:0] page_tab(input logic [19:0] vpn);
        if (vpn >= 20'h10 && vpn <= 20'h14) return {1'b1, 2'b10, 20'h80 + (vpn - 20'h10)};
        if (vpn == 20'h0F)                   return {1'b1, 2'b00, 20'h7F};
        if (vpn >= 20'h20 && vpn <= 20'h2F)  return {1'b1, 2'b00, vpn + 20'h100};
        if (vpn >= 20'h30 && vpn <= 20'h3F)  return {1'b1, 2'b01, vpn + 20'h200};
        if (vpn == 20'h40)                   return {1'b0, 2'b10, 20'h0};
        if (vpn == 20'h41)                   return {1'b1, 2'b11, vpn};
        return {1'b1, 2'b00, vpn};
    endfunction

    function automatic logic [1:0] exp_route(input logic [31:0] pa, input logic [1:0] cls);
        if (pa >= base && pa < limit) return 2'd0;
        if (cls == 2'b01)             return 2'd2;
        return 2'd1;
    endfunction

    // Refill responder: answers the third cycle a request is seen.
    int lat = 0;
    always @(posedge clk) begin
        #2;
        mmu_rsp_valid = 1'b0;
        if (rst_n && mmu_req_valid) begin
            lat++;
            if (lat == 3) begin
                {mmu_pres, mmu_cls, mmu_ppn} = page_tab(mmu_vpn);
                mmu_rsp_valid = 1'b1;
                lat = 0;
            end
        end else begin
            lat = 0;
        end
    end

    // Reference model state.
    logic [19:0] m_vpn [4];
    logic [19:0] m_ppn [4];
    logic [1:0]  m_cls [4];
    bit          m_val [4];
    int          m_ptr, m_hi;
    bit          m_busy, m_rv, m_flt, m_acc, m_hit, m_load;
    logic [19:0] m_mvpn;
    logic [11:0] m_moff;
    logic [31:0] m_pa;
    logic [1:0]  m_tgt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_val[i] = 0;
            m_ptr = 0; m_busy = 0; m_rv = 0; m_flt = 0; m_pa = 0; m_tgt = 3;
        end else begin
            m_acc = req_valid && !m_busy && (!m_rv || rsp_ready);
            m_hit = 0; m_hi = 0; m_load = 0;
            for (int i = 0; i < 4; i++)
                if (m_val[i] && m_vpn[i] == vaddr[31:12]) begin m_hit = 1; m_hi = i; end
            if (flush) begin
                m_hit = 0;
                for (int i = 0; i < 4; i++) m_val[i] = 0;
            end
            if (m_busy && mmu_rsp_valid) begin
                m_busy = 0; m_load = 1; m_rv = 1;
                if (mmu_pres && mmu_cls != 2'b11) begin
                    m_vpn[m_ptr] = m_mvpn; m_ppn[m_ptr] = mmu_ppn;
                    m_cls[m_ptr] = mmu_cls; m_val[m_ptr] = 1;
                    m_ptr = (m_ptr + 1) % 4;
                    m_pa = {mmu_ppn, m_moff}; m_tgt = exp_route(m_pa, mmu_cls); m_flt = 0;
                end else begin
                    m_pa = 0; m_tgt = 3; m_flt = 1;
                end
            end
            if (m_acc) begin
                if (m_hit) begin
                    m_load = 1; m_rv = 1; m_flt = 0;
                    m_pa = {m_ppn[m_hi], vaddr[11:0]};
                    m_tgt = exp_route(m_pa, m_cls[m_hi]);
                end else begin
                    m_busy = 1; m_mvpn = vaddr[31:12]; m_moff = vaddr[11:0];
                end
            end
            if (!m_load && rsp_ready) m_rv = 0;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 req_ready", req_ready, !m_busy && (!m_rv || rsp_ready));
            chk("R4 mmu_req_valid", mmu_req_valid, m_busy);
            if (m_busy) chk("R4 mmu_req_vpn", mmu_vpn, m_mvpn);
            chk("R1 rsp_valid", rsp_valid, m_rv);
            if (m_rv) begin
                case (m_tgt)
                    2'd0: chk("R2 paddr/target/fault", {rsp_paddr, rsp_target, rsp_fault}, {m_pa, m_tgt, m_flt});
                    2'd1: chk("R3 paddr/target/fault", {rsp_paddr, rsp_target, rsp_fault}, {m_pa, m_tgt, m_flt});
                    2'd2: chk("R5 paddr/target/fault", {rsp_paddr, rsp_target, rsp_fault}, {m_pa, m_tgt, m_flt});
                    default: chk("R6 paddr/target/fault", {rsp_paddr, rsp_target, rsp_fault}, {m_pa, m_tgt, m_flt});
                endcase
            end
        end
    end

    // Issue one fetch and check its response; hit=1 expects a one-cycle answer.
    task automatic fetch(input logic [31:0] va, input logic [31:0] epa, input logic [1:0] etgt,
                         input bit eflt, input bit hit, input bit fl, input string tag);
        int n;
        @(posedge clk); #2;
        req_valid = 1'b1; vaddr = va; flush = fl;
        while (!req_ready) begin @(posedge clk); #2; end
        @(posedge clk); #2;
        req_valid = 1'b0; flush = 1'b0; n = 1;
        while (!rsp_valid && n < 50) begin @(posedge clk); #2; n++; end
        chk({tag, " paddr"}, rsp_paddr, epa);
        chk({tag, " target"}, rsp_target, etgt);
        chk({tag, " fault"}, rsp_fault, eflt);
        chk({tag, " hit latency"}, (n == 1), hit);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        #1;
        chk("R10 reset req_ready", req_ready, 1'b1);
        chk("R10 reset rsp_valid", rsp_valid, 1'b0);
        chk("R10 reset mmu_req", mmu_req_valid, 1'b0);

        fetch(32'h0001_0123, 32'h0008_0123, 2'd0, 0, 0, 0, "R4 R2 first miss into window");
        fetch(32'h0001_0456, 32'h0008_0456, 2'd0, 0, 1, 0, "R1 hit same page");
        fetch(32'h0001_3FFC, 32'h0008_3FFC, 2'd0, 0, 0, 0, "R2 last window word");
        fetch(32'h0001_4000, 32'h0008_4000, 2'd1, 0, 0, 0, "R3 at limit goes to mini-cache");
        fetch(32'h0003_0010, 32'h0023_0010, 2'd2, 0, 0, 0, "R5 non-cacheable");
        fetch(32'h0002_0008, 32'h0012_0008, 2'd1, 0, 0, 0, "R3 cacheable fifth page");
        fetch(32'h0001_3000, 32'h0008_3000, 2'd0, 0, 1, 0, "R7 second fill survives");
        fetch(32'h0001_0000, 32'h0008_0000, 2'd0, 0, 0, 0, "R7 first fill evicted");
        fetch(32'h0004_0000, 32'h0000_0000, 2'd3, 1, 0, 0, "R6 absent pageable page");
        fetch(32'h0004_0000, 32'h0000_0000, 2'd3, 1, 0, 0, "R6 absent page not installed");
        fetch(32'h0004_1000, 32'h0000_0000, 2'd3, 1, 0, 0, "R6 reserved class");
        fetch(32'h0000_FFFF, 32'h0007_FFFF, 2'd1, 0, 0, 0, "R3 just below base");
        fetch(32'h0000_F000, 32'h0007_F000, 2'd1, 0, 1, 0, "R1 hit below base");

        @(posedge clk); #2; flush = 1'b1;
        @(posedge clk); #2; flush = 1'b0;
        fetch(32'h0000_F000, 32'h0007_F000, 2'd1, 0, 0, 0, "R8 miss after flush pulse");
        fetch(32'h0000_F004, 32'h0007_F004, 2'd1, 0, 0, 1, "R8 flush with fetch misses");

        // R9: hold the consumer off with a hit pending, then offer another fetch.
        @(posedge clk); #2;
        rsp_ready = 1'b0; req_valid = 1'b1; vaddr = 32'h0000_F008;
        @(posedge clk); #2;
        vaddr = 32'h0000_F00C;
        for (int k = 0; k < 3; k++) begin
            chk("R9 held rsp_valid", rsp_valid, 1'b1);
            chk("R9 held paddr", rsp_paddr, 32'h0007_F008);
            chk("R9 fetch refused", req_ready, 1'b0);
            @(posedge clk); #2;
        end
        rsp_ready = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
        chk("R9 next fetch paddr", rsp_paddr, 32'h0007_F00C);
        chk("R1 next fetch valid", rsp_valid, 1'b1);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule